// File: doc/BRIEF.md
# External Bus Mastership Handover Controller

This controller decides who drives the local memory bus: the local bus sequencer or an external master. An external master asks for the bus by pulling an active-low request line low. The controller lets any local cycle in progress finish. It then floats the address, data and strobe/chip-select lines by dropping their output enables, turns on an external buffer enable, and answers on an active-low acknowledge line. When the request line goes high again, the controller takes the bus back in a fixed sequence of stages. Each stage happens on a given edge of the bus clock.

The block runs on a clock at twice the bus-clock rate and produces the bus clock itself (`bclk`). A clock edge at which `bclk` goes from 1 to 0 is a falling bus edge, and one at which it goes from 0 to 1 is a rising bus edge. Two flags tell the local sequencer what it may do: `released` says the bus is away or not yet fully back, and `resume_ok` says a new local cycle may start. Sleep and manual-reset requests are held while the bus is away. A standby input makes the controller ignore requests and puts the acknowledge pin into high impedance.

Top module: `bus_handover`

## Requirements
- R1: While `rst_n` is low and right after it goes high, the controller owns the bus. The outputs are `back_n`=1, `addr_oe`=`data_oe`=`ctrl_oe`=1, `ext_en`=0, `released`=0, `resume_ok`=1, `proto_err`=0 and `bclk`=0.
- R2: `bclk` toggles on every clock edge. A falling bus edge is a clock edge taken while `bclk` is 1.
- R3: `breq_n` passes through SYNC_STAGES flip-flops clocked on every edge and is acted on only at falling bus edges. Suppose the controller owns the bus, `standby` is 0, and it sees a request at a falling bus edge. It then stops driving `resume_ok` high from that edge on, and keeps `back_n` high.
- R4: While a request is pending and `busy` is 0 at a falling bus edge, the controller releases the bus at that edge. `back_n`, `addr_oe`, `data_oe` and `ctrl_oe` go low, and `ext_en` and `released` go high.
- R5: Suppose the released bus sees the request negated at a falling bus edge T. `back_n` goes high at T, and `ctrl_oe` goes high RECLAIM_HALF clock edges later, which is a rising bus edge (3 edges by default, 1.5 bus cycles).
- R6: `ext_en` goes low at the next falling bus edge after `ctrl_oe` went high, one clock edge later.
- R7: `addr_oe`, `data_oe` and `resume_ok` go high and `released` goes low at the next rising bus edge after R6. `addr_oe` is never high while `ctrl_oe` is low.
- R8: A `sleep_req` or `mrst_req` pulse is held pending while the controller does not own the bus. It then produces a one-edge `sleep_go`/`mrst_go` pulse on the edge after ownership is back. In the owned state, a request gives its go pulse on the next edge.
- R9: While `standby` is 1, `back_oe` is 0 and a request seen in the owned state is ignored, so every output holds its owned value.
- R10: Suppose the request is withdrawn before acknowledge, so it is inactive at the falling bus edge where the release happens. `proto_err` is then high for that one clock edge, and `back_n` stays low for exactly two clock edges (one bus cycle).
- R11: While `busy` is 1, a pending request does not release the bus. `back_n` stays high and all output enables stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bus-clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| breq_n | input | 1 | Asynchronous active-low bus request from the external master |
| busy | input | 1 | Local bus cycle in progress |
| standby | input | 1 | Standby mode: requests ignored, acknowledge floated |
| sleep_req | input | 1 | Sleep/standby entry request pulse |
| mrst_req | input | 1 | Manual reset request pulse |
| bclk | output | 1 | Generated bus clock |
| back_n | output | 1 | Active-low bus acknowledge |
| back_oe | output | 1 | Output enable of the acknowledge pin |
| addr_oe | output | 1 | Address output enable |
| data_oe | output | 1 | Data output enable |
| ctrl_oe | output | 1 | Strobe and chip-select output enable |
| ext_en | output | 1 | External buffer enable, high while the bus is away |
| released | output | 1 | Mastership not fully held |
| resume_ok | output | 1 | A new local bus cycle may start |
| proto_err | output | 1 | Request withdrawn before acknowledge |
| sleep_go | output | 1 | Granted sleep/standby entry pulse |
| mrst_go | output | 1 | Granted manual reset pulse |

## Verification
The checker verifies on every edge the rules that hold at all times. The acknowledge is never low while the bus is still driven. Address is never driven without control. Control reasserts only on a rising bus edge, and the buffer enable drops only on a falling one. Standby always floats the acknowledge. A go pulse appears only when ownership held on the previous edge, and an error pulse comes only with acknowledge low. The exact edge counts of the reclaim sequence can only be shown by the bench's scenarios: a normal handover, a handover delayed by `busy`, an early withdrawal, standby, and held sleep and reset requests. Those counts are the distance from request negation to control reassertion and the one-edge steps that follow.

// File: rtl/bho_pkg.sv
package bho_pkg;
   typedef enum logic [5:0] {
      ST_OWNED    = 6'b000001,
      ST_WAIT     = 6'b000010,
      ST_AWAY     = 6'b000100,
      ST_RC_CTRL  = 6'b001000,
      ST_RC_EN    = 6'b010000,
      ST_RC_READY = 6'b100000
   } hs_state_t;

   function automatic logic st_drives_addr(hs_state_t s);
      return (s == ST_OWNED) || (s == ST_WAIT);
   endfunction

   function automatic logic st_drives_ctrl(hs_state_t s);
      return (s == ST_OWNED) || (s == ST_WAIT) || (s == ST_RC_EN) || (s == ST_RC_READY);
   endfunction

   function automatic logic st_buf_on(hs_state_t s);
      return (s == ST_AWAY) || (s == ST_RC_CTRL) || (s == ST_RC_EN);
   endfunction
endpackage

// File: rtl/bho_sync.sv
module bho_sync #(
   parameter int STAGES = 2,
   parameter bit RESET_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("bho_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RESET_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/bho_phase.sv
module bho_phase (
   input  logic clk,
   input  logic rst_n,
   output logic bclk,
   output logic fall_tick,
   output logic rise_tick
);
   logic ph;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph <= 1'b0;
      else        ph <= ~ph;
   end

   assign bclk      = ph;
   assign fall_tick = ph;
   assign rise_tick = ~ph;
endmodule

// File: rtl/bho_hold.sv
module bho_hold (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic owned,
   output logic go
);
   logic pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= 1'b0;
         go   <= 1'b0;
      end else if (owned && (pend || req)) begin
         pend <= 1'b0;
         go   <= 1'b1;
      end else begin
         go <= 1'b0;
         if (req) pend <= 1'b1;
      end
   end
endmodule

// File: rtl/bho_fsm.sv
module bho_fsm
   import bho_pkg::*;
#(
   parameter int RECLAIM_HALF = 3
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      fall_tick,
   input  logic      rise_tick,
   input  logic      req,
   input  logic      busy,
   input  logic      standby,
   output hs_state_t st,
   output logic      proto_err
);
   localparam int CW = $clog2(RECLAIM_HALF + 1);
   localparam logic [CW-1:0] LOAD = CW'(RECLAIM_HALF - 1);

   if (RECLAIM_HALF < 1 || (RECLAIM_HALF % 2) == 0) begin : g_bad_delay
      $error("bho_fsm: RECLAIM_HALF must be odd so control returns on a rising edge");
   end

   hs_state_t st_nx;
   logic [CW-1:0] cnt, cnt_nx;
   logic err_nx;

   always_comb begin
      st_nx  = st;
      cnt_nx = cnt;
      err_nx = 1'b0;
      unique case (st)
         ST_OWNED:
            if (fall_tick && req && !standby) st_nx = ST_WAIT;
         ST_WAIT:
            if (fall_tick && !busy) begin
               st_nx  = ST_AWAY;
               err_nx = !req;
            end
         ST_AWAY:
            if (fall_tick && !req) begin
               st_nx  = ST_RC_CTRL;
               cnt_nx = LOAD;
            end
         ST_RC_CTRL:
            if (cnt == '0) st_nx = ST_RC_EN;
            else           cnt_nx = cnt - 1'b1;
         ST_RC_EN:
            if (fall_tick) st_nx = ST_RC_READY;
         ST_RC_READY:
            if (rise_tick) st_nx = ST_OWNED;
         default:
            st_nx = ST_OWNED;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_OWNED;
         cnt       <= '0;
         proto_err <= 1'b0;
      end else begin
         st        <= st_nx;
         cnt       <= cnt_nx;
         proto_err <= err_nx;
      end
   end
endmodule

// File: rtl/bus_handover.sv
module bus_handover
   import bho_pkg::*;
#(
   parameter int SYNC_STAGES  = 2,
   parameter int RECLAIM_HALF = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic breq_n,
   input  logic busy,
   input  logic standby,
   input  logic sleep_req,
   input  logic mrst_req,
   output logic bclk,
   output logic back_n,
   output logic back_oe,
   output logic addr_oe,
   output logic data_oe,
   output logic ctrl_oe,
   output logic ext_en,
   output logic released,
   output logic resume_ok,
   output logic proto_err,
   output logic sleep_go,
   output logic mrst_go
);
   localparam int NHOLD = 2;

   logic req_s, fall_tick, rise_tick;
   hs_state_t st;
   logic [NHOLD-1:0] hold_req, hold_go;

   bho_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(~breq_n), .q(req_s)
   );

   bho_phase u_phase (
      .clk(clk), .rst_n(rst_n), .bclk(bclk),
      .fall_tick(fall_tick), .rise_tick(rise_tick)
   );

   bho_fsm #(.RECLAIM_HALF(RECLAIM_HALF)) u_fsm (
      .clk(clk), .rst_n(rst_n), .fall_tick(fall_tick), .rise_tick(rise_tick),
      .req(req_s), .busy(busy), .standby(standby), .st(st), .proto_err(proto_err)
   );

   assign hold_req = {mrst_req, sleep_req};

   for (genvar i = 0; i < NHOLD; i++) begin : g_hold
      bho_hold u_hold (
         .clk(clk), .rst_n(rst_n), .req(hold_req[i]),
         .owned(st == ST_OWNED), .go(hold_go[i])
      );
   end

   assign sleep_go  = hold_go[0];
   assign mrst_go   = hold_go[1];
   assign addr_oe   = st_drives_addr(st);
   assign data_oe   = st_drives_addr(st);
   assign ctrl_oe   = st_drives_ctrl(st);
   assign ext_en    = st_buf_on(st);
   assign back_n    = (st != ST_AWAY);
   assign back_oe   = ~standby;
   assign released  = !st_drives_addr(st);
   assign resume_ok = (st == ST_OWNED);
endmodule

module bho_checker
   import bho_pkg::*;
(
   input logic      clk,
   input logic      rst_n,
   input logic      standby,
   input logic      bclk,
   input logic      back_n,
   input logic      back_oe,
   input logic      addr_oe,
   input logic      ctrl_oe,
   input logic      ext_en,
   input logic      resume_ok,
   input logic      proto_err,
   input logic      sleep_go,
   input logic      mrst_go,
   input hs_state_t st
);
   p_onehot_state_r3: assert property (@(posedge clk) disable iff (!rst_n) $onehot(st));
   p_ack_floats_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !back_n |-> (!addr_oe && !ctrl_oe && ext_en));
   p_ctrl_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctrl_oe) |-> bclk);
   p_en_drop_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ext_en) |-> (!bclk && ctrl_oe));
   p_addr_needs_ctrl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      addr_oe |-> ctrl_oe);
   p_go_when_owned_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_go || mrst_go) |-> $past(resume_ok));
   p_standby_hiz_r9: assert property (@(posedge clk) disable iff (!rst_n)
      standby |-> !back_oe);
   p_err_with_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err |-> !back_n);
endmodule

bind bus_handover bho_checker u_chk (
   .clk(clk), .rst_n(rst_n), .standby(standby), .bclk(bclk), .back_n(back_n),
   .back_oe(back_oe), .addr_oe(addr_oe), .ctrl_oe(ctrl_oe), .ext_en(ext_en),
   .resume_ok(resume_ok), .proto_err(proto_err), .sleep_go(sleep_go),
   .mrst_go(mrst_go), .st(st)
);

// File: tb/bus_handover_test.sv
`timescale 1ns/1ps
module bus_handover_test;
   logic clk = 1'b0, rst_n = 1'b0;
   logic breq_n = 1'b1, busy = 1'b0, standby = 1'b0, sleep_req = 1'b0, mrst_req = 1'b0;
   logic bclk, back_n, back_oe, addr_oe, data_oe, ctrl_oe, ext_en;
   logic released, resume_ok, proto_err, sleep_go, mrst_go;

   int vectors = 0, miscompares = 0;
   bit done = 0;

   always #10 clk = ~clk;

   bus_handover uut (
      .clk(clk), .rst_n(rst_n), .breq_n(breq_n), .busy(busy), .standby(standby),
      .sleep_req(sleep_req), .mrst_req(mrst_req), .bclk(bclk), .back_n(back_n),
      .back_oe(back_oe), .addr_oe(addr_oe), .data_oe(data_oe), .ctrl_oe(ctrl_oe),
      .ext_en(ext_en), .released(released), .resume_ok(resume_ok),
      .proto_err(proto_err), .sleep_go(sleep_go), .mrst_go(mrst_go)
   );

   // behavioural reference: 0 owned, 1 waiting, 2 away, 3 ctrl delay, 4 enable off, 5 ready
   int m_mode = 0, m_wait = 0;
   bit m_ph = 0, m_err = 0, m_sgo = 0, m_rgo = 0, m_spend = 0, m_rpend = 0;
   bit m_sync[$] = '{0, 0};

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_mode = 0; m_wait = 0; m_ph = 0; m_err = 0;
         m_sgo = 0; m_rgo = 0; m_spend = 0; m_rpend = 0;
         m_sync = '{0, 0};
      end else begin
         bit falling, want, own;
         falling = m_ph;
         want = m_sync[1];
         own = (m_mode == 0);
         m_sgo = own && (m_spend || sleep_req);
         if (m_sgo) m_spend = 0; else if (sleep_req) m_spend = 1;
         m_rgo = own && (m_rpend || mrst_req);
         if (m_rgo) m_rpend = 0; else if (mrst_req) m_rpend = 1;
         m_err = 0;
         case (m_mode)
            0: if (falling && want && !standby) m_mode = 1;
            1: if (falling && !busy) begin m_mode = 2; m_err = !want; end
            2: if (falling && !want) begin m_mode = 3; m_wait = 3; end
            3: begin m_wait--; if (m_wait == 0) m_mode = 4; end
            4: if (falling) m_mode = 5;
            5: if (!falling) m_mode = 0;
            default: m_mode = 0;
         endcase
         m_sync.push_front(!breq_n);
         void'(m_sync.pop_back());
         m_ph = !m_ph;
      end
   end

   task automatic check(string tag, string what, logic act, logic exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit own, drv;
         own = (m_mode == 0 || m_mode == 1);
         drv = own || m_mode == 4 || m_mode == 5;
         check("R2", "bclk", bclk, m_ph);
         check("R3", "resume_ok", resume_ok, m_mode == 0);
         check("R4", "back_n", back_n, m_mode != 2);
         check("R4", "released", released, !own);
         check("R5", "ctrl_oe", ctrl_oe, drv);
         check("R6", "ext_en", ext_en, m_mode >= 2 && m_mode <= 4);
         check("R7", "addr_oe", addr_oe, own);
         check("R7", "data_oe", data_oe, own);
         check("R8", "sleep_go", sleep_go, m_sgo);
         check("R8", "mrst_go", mrst_go, m_rgo);
         check("R9", "back_oe", back_oe, !standby);
         check("R10", "proto_err", proto_err, m_err);
      end
   end

   // edge-distance monitor for the reclaim sequence
   int tick = 0, t_back_up = -100, t_ctrl_up = -100, t_back_dn = -100;
   logic p_back = 1, p_ctrl = 1, p_en = 0, p_addr = 1;
   always @(negedge clk) begin
      tick++;
      if (rst_n && !done) begin
         if (!p_back && back_n) begin
            t_back_up = tick;
            if (proto_err === 1'b0 && (tick - t_back_dn) == 2)
               $display("note: short acknowledge observed at %0t", $time);
         end
         if (p_back && !back_n) t_back_dn = tick;
         if (!p_ctrl && ctrl_oe) begin
            t_ctrl_up = tick;
            check("R5", "ctrl edge distance ok", (tick - t_back_up) == 3, 1'b1);
            check("R5", "ctrl on rising bus edge", bclk, 1'b1);
         end
         if (p_en && !ext_en) check("R6", "enable drop one edge later", (tick - t_ctrl_up) == 1, 1'b1);
         if (!p_addr && addr_oe) check("R7", "addr two edges later", (tick - t_ctrl_up) == 2, 1'b1);
      end
      p_back = back_n; p_ctrl = ctrl_oe; p_en = ext_en; p_addr = addr_oe;
   end

   task automatic edges(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_for_ack(int lim);
      for (int i = 0; i < lim && back_n !== 1'b0; i++) @(negedge clk);
   endtask

   task automatic wait_owned(int lim);
      for (int i = 0; i < lim && resume_ok !== 1'b1; i++) @(negedge clk);
   endtask

   task automatic pulse_sleep();
      sleep_req = 1'b1; @(negedge clk); sleep_req = 1'b0;
   endtask

   task automatic pulse_mrst();
      mrst_req = 1'b1; @(negedge clk); mrst_req = 1'b0;
   endtask

   initial begin
      edges(3);
      // R1 reset state while held in reset
      check("R1", "back_n in reset", back_n, 1'b1);
      check("R1", "addr_oe in reset", addr_oe, 1'b1);
      check("R1", "ctrl_oe in reset", ctrl_oe, 1'b1);
      check("R1", "ext_en in reset", ext_en, 1'b0);
      check("R1", "resume_ok in reset", resume_ok, 1'b1);
      check("R1", "bclk in reset", bclk, 1'b0);
      rst_n = 1'b1;
      edges(4);
      check("R1", "owned after reset", released, 1'b0);

      // normal handover (R3, R4, R5, R6, R7)
      breq_n = 1'b0;
      wait_for_ack(40);
      check("R4", "acknowledge given", back_n, 1'b0);
      edges(10);
      breq_n = 1'b1;
      wait_owned(40);
      check("R7", "ownership back", resume_ok, 1'b1);
      edges(6);

      // busy delays release (R11)
      busy = 1'b1;
      breq_n = 1'b0;
      edges(12);
      check("R11", "no ack while busy", back_n, 1'b1);
      check("R11", "addr driven while busy", addr_oe, 1'b1);
      check("R3", "cycles stopped while waiting", resume_ok, 1'b0);
      busy = 1'b0;
      wait_for_ack(40);
      check("R4", "ack after busy clears", back_n, 1'b0);
      // R8 requests held while away
      pulse_sleep();
      pulse_mrst();
      edges(4);
      breq_n = 1'b1;
      wait_owned(40);
      edges(6);

      // early withdrawal (R10)
      busy = 1'b1;
      breq_n = 1'b0;
      edges(8);
      breq_n = 1'b1;
      edges(6);
      busy = 1'b0;
      wait_for_ack(20);
      check("R10", "short ack given", back_n, 1'b0);
      wait_owned(40);
      edges(6);

      // standby ignores requests (R9)
      standby = 1'b1;
      breq_n = 1'b0;
      edges(20);
      check("R9", "ignored under standby", resume_ok, 1'b1);
      check("R9", "ack floated", back_oe, 1'b0);
      breq_n = 1'b1;
      edges(6);
      standby = 1'b0;

      // R8 request while owned
      pulse_sleep();
      edges(4);
      pulse_mrst();
      edges(8);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         miscompares++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule